// File: doc/BRIEF.md
# Linear CCD Line Timing Generator

This block drives the digital gate and clock pulses of a three-colour linear CCD whose colour channels each read out through an odd/even pair of output taps. Every transfer period moves one pixel pair onto each tap pair, so one pulse train serves all six outputs. A start strobe begins a line cycle. The cycle runs in this order: a lead interval, the shift-gate pulse that moves charge from the photodiodes into the transfer registers, a hold interval, and then a readout of 3822 transfer periods.

During readout the block drives the following outputs:
- the two-phase transfer clocks and the last-stage clock;
- a reset-gate pulse in every period;
- a clamp pulse, either in every period (bit clamp) or once per line (line clamp).

For each period the block also reports a segment tag and a pixel-valid flag, which a downstream capture path uses to keep signal pixels and to average the optical-black pixels. All timing comes from register inputs counted in system-clock ticks, and every output leaves a flip-flop.

Top module: `ccd_line_timer`

## Requirements
- R1: While reset is asserted, and after reset until a start is accepted, the outputs are in their idle levels: sh=0, phi1a=1, phi2a=0, phi2b=0, rs=0, cp=0, pix_valid=0, seg_tag=0, line_done=0.
- R2: Readout has 3822 periods of cfg_period ticks each. In each period phi1a is high for the first floor(cfg_period/2) ticks and low for the rest. phi2a is always the complement of phi1a, and phi2b always equals phi2a.
- R3: seg_tag holds the segment of the current readout period. The encoding is 0 dummy, 1 shielded, 2 signal, 3 trailing. Periods 0–7 and 56–63 are dummy, periods 8–55 are shielded, periods 64–3813 are signal, and periods 3814–3821 are trailing. pix_valid is high exactly in the signal periods. Outside readout, seg_tag is 0 and pix_valid is 0.
- R4: An accepted start is followed by cfg_lead ticks with sh low and phi1a high. Then sh is high for cfg_sh_width ticks, and then come cfg_hold ticks with sh low and phi1a high. phi1a stays high through the whole sh pulse.
- R5: rs and cp stay low from the accepted start until readout period 0 begins. The hold interval therefore sets the delay from the sh falling edge to the first rs pulse.
- R6: In bit-clamp mode (cfg_line_clamp=0), rs is high for the first cfg_rs_width ticks of every readout period. cp is high for the next cfg_cp_width ticks, so rs and cp never overlap.
- R7: In line-clamp mode (cfg_line_clamp=1), cp pulses only in readout period 0, in the same tick slot as in bit-clamp mode. rs still pulses in every period.
- R8: A start is accepted only if the block is idle and, for every line after the first, at least cfg_integ clocks have passed since the previous accepted start. A start that arrives at any other time has no effect. This makes the sh-to-sh interval at least cfg_integ.
- R9: line_done is high for exactly one clock, in the tick that follows the last tick of readout period 3821.
- R10: Outputs first change one clock after the edge that accepts a start. A start held high for several clocks launches only one line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Line start request |
| cfg_period | input | 16 | Ticks per transfer period (at least 2) |
| cfg_lead | input | 16 | Ticks of phi1a high before sh rises (at least 1) |
| cfg_sh_width | input | 16 | sh pulse width in ticks (at least 1) |
| cfg_hold | input | 16 | Ticks from sh fall to readout start (at least 1) |
| cfg_rs_width | input | 16 | rs pulse width in ticks |
| cfg_cp_width | input | 16 | cp pulse width in ticks |
| cfg_line_clamp | input | 1 | 1 selects line clamp, 0 selects bit clamp |
| cfg_integ | input | 32 | Minimum clocks between accepted starts |
| sh | output | 1 | Shift gate |
| phi1a | output | 1 | Transfer clock, phase 1 |
| phi2a | output | 1 | Transfer clock, phase 2 |
| phi2b | output | 1 | Last-stage clock |
| rs | output | 1 | Reset gate |
| cp | output | 1 | Clamp gate |
| pix_valid | output | 1 | Current period carries signal pixels |
| seg_tag | output | 2 | Segment of the current period |
| line_done | output | 1 | One-clock end-of-line pulse |

## Verification
The bench targets the segment boundaries at periods 7/8, 55/56, 63/64 and 3813/3814. A design that is off by one period there would mark a dummy or shielded pixel as valid, or would corrupt the black-level window. It also uses an odd transfer period, which catches a rounding error in the phi1a split. It checks the first and last tick of the sh pulse, where a late phi1a or an early rs would disturb the charge transfer. It sends starts during a readout, in the clock right after line_done before the integration interval has passed, and as a start held high for two clocks. A design that re-triggered on any of these would produce a second sh pulse, visible against the model.

// File: rtl/ccd_line_timer.sv
module ccd_line_timer #(
  parameter int LEAD_N     = 64,
  parameter int SHIELD_OFS = 8,
  parameter int SHIELD_N   = 48,
  parameter int SIGNAL_N   = 3750,
  parameter int TRAIL_N    = 8,
  parameter int TW         = 16,
  parameter int IW         = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [TW-1:0] cfg_period,
  input  logic [TW-1:0] cfg_lead,
  input  logic [TW-1:0] cfg_sh_width,
  input  logic [TW-1:0] cfg_hold,
  input  logic [TW-1:0] cfg_rs_width,
  input  logic [TW-1:0] cfg_cp_width,
  input  logic          cfg_line_clamp,
  input  logic [IW-1:0] cfg_integ,
  output logic          sh,
  output logic          phi1a,
  output logic          phi2a,
  output logic          phi2b,
  output logic          rs,
  output logic          cp,
  output logic          pix_valid,
  output logic [1:0]    seg_tag,
  output logic          line_done
);
  localparam int LINE_N      = LEAD_N + SIGNAL_N + TRAIL_N;
  localparam int PW          = $clog2(LINE_N);
  localparam int SHIELD_END  = SHIELD_OFS + SHIELD_N;
  localparam int TRAIL_START = LEAD_N + SIGNAL_N;

  typedef enum logic [2:0] {IDLE, LEAD, SHP, HOLD, READ} state_t;

  state_t        st;
  logic [TW-1:0] tcnt;
  logic [PW-1:0] pcnt;
  logic [IW-1:0] since;
  logic          armed, done_r;

  wire accept   = (st == IDLE) && start && (!armed || since >= cfg_integ);
  wire tick_end = 1'b1;
  wire per_last = (tcnt == cfg_period - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= IDLE;
      tcnt   <= '0;
      pcnt   <= '0;
      since  <= '0;
      armed  <= 1'b0;
      done_r <= 1'b0;
    end else begin
      done_r <= 1'b0;
      if (accept) since <= IW'(1);
      else if (since != '1) since <= since + 1'b1;
      case (st)
        IDLE: if (accept) begin
          st    <= LEAD;
          tcnt  <= '0;
          armed <= 1'b1;
        end
        LEAD: if (tcnt == cfg_lead - 1'b1) begin
          st <= SHP; tcnt <= '0;
        end else tcnt <= tcnt + 1'b1;
        SHP: if (tcnt == cfg_sh_width - 1'b1) begin
          st <= HOLD; tcnt <= '0;
        end else tcnt <= tcnt + 1'b1;
        HOLD: if (tcnt == cfg_hold - 1'b1) begin
          st <= READ; tcnt <= '0; pcnt <= '0;
        end else tcnt <= tcnt + 1'b1;
        READ: if (per_last && tick_end) begin
          tcnt <= '0;
          if (pcnt == PW'(LINE_N - 1)) begin
            st     <= IDLE;
            done_r <= 1'b1;
          end else pcnt <= pcnt + 1'b1;
        end else tcnt <= tcnt + 1'b1;
        default: st <= IDLE;
      endcase
    end
  end

  logic       n_sh, n_phi1, n_rs, n_cp, n_valid;
  logic [1:0] n_tag;
  logic [TW:0] cp_end;

  assign cp_end = {1'b0, cfg_rs_width} + {1'b0, cfg_cp_width};

  always_comb begin
    n_sh    = (st == SHP);
    n_phi1  = 1'b1;
    n_rs    = 1'b0;
    n_cp    = 1'b0;
    n_tag   = 2'd0;
    n_valid = 1'b0;
    if (st == READ) begin
      n_phi1 = tcnt < (cfg_period >> 1);
      n_rs   = tcnt < cfg_rs_width;
      n_cp   = (tcnt >= cfg_rs_width) && ({1'b0, tcnt} < cp_end) &&
               (!cfg_line_clamp || pcnt == '0);
      if (pcnt >= PW'(TRAIL_START))     n_tag = 2'd3;
      else if (pcnt >= PW'(LEAD_N))     n_tag = 2'd2;
      else if (pcnt >= PW'(SHIELD_OFS) && pcnt < PW'(SHIELD_END)) n_tag = 2'd1;
      n_valid = (n_tag == 2'd2);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh        <= 1'b0;
      phi1a     <= 1'b1;
      phi2a     <= 1'b0;
      phi2b     <= 1'b0;
      rs        <= 1'b0;
      cp        <= 1'b0;
      pix_valid <= 1'b0;
      seg_tag   <= 2'd0;
      line_done <= 1'b0;
    end else begin
      sh        <= n_sh;
      phi1a     <= n_phi1;
      phi2a     <= ~n_phi1;
      phi2b     <= ~n_phi1;
      rs        <= n_rs;
      cp        <= n_cp;
      pix_valid <= n_valid;
      seg_tag   <= n_tag;
      line_done <= done_r;
    end
  end
endmodule

// File: rtl/ccd_line_timer_chk.sv
module ccd_line_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sh,
  input logic       phi1a,
  input logic       phi2a,
  input logic       phi2b,
  input logic       rs,
  input logic       cp,
  input logic       pix_valid,
  input logic [1:0] seg_tag,
  input logic       line_done
);
  a_r2_phase_complement: assert property (@(posedge clk) disable iff (!rst_n)
    phi2a == !phi1a);
  a_r2_last_stage_follows: assert property (@(posedge clk) disable iff (!rst_n)
    phi2b == phi2a);
  a_r3_valid_only_signal: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> seg_tag == 2'd2);
  a_r4_phi1_over_sh: assert property (@(posedge clk) disable iff (!rst_n)
    sh |-> phi1a);
  a_r4_phi1_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sh) |-> phi1a);
  a_r5_quiet_during_sh: assert property (@(posedge clk) disable iff (!rst_n)
    sh |-> (!rs && !cp && !pix_valid));
  a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(rs && cp));
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |=> !line_done);
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |-> (!sh && !rs && !cp && seg_tag == 2'd0));
endmodule

bind ccd_line_timer ccd_line_timer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sh(sh), .phi1a(phi1a), .phi2a(phi2a),
  .phi2b(phi2b), .rs(rs), .cp(cp), .pix_valid(pix_valid),
  .seg_tag(seg_tag), .line_done(line_done)
);

// File: tb/ccd_line_timer_tb_top.sv
`timescale 1ns/1ps
module ccd_line_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] cfg_period = 16'd6, cfg_lead = 16'd3, cfg_sh_width = 16'd8;
  logic [15:0] cfg_hold = 16'd4, cfg_rs_width = 16'd1, cfg_cp_width = 16'd1;
  logic        cfg_line_clamp = 1'b0;
  logic [31:0] cfg_integ = 32'd23000;
  logic sh, phi1a, phi2a, phi2b, rs, cp, pix_valid, line_done;
  logic [1:0] seg_tag;

  always #2.5 clk = ~clk;

  ccd_line_timer dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_period(cfg_period),
    .cfg_lead(cfg_lead), .cfg_sh_width(cfg_sh_width), .cfg_hold(cfg_hold),
    .cfg_rs_width(cfg_rs_width), .cfg_cp_width(cfg_cp_width),
    .cfg_line_clamp(cfg_line_clamp), .cfg_integ(cfg_integ),
    .sh(sh), .phi1a(phi1a), .phi2a(phi2a), .phi2b(phi2b), .rs(rs), .cp(cp),
    .pix_valid(pix_valid), .seg_tag(seg_tag), .line_done(line_done)
  );

  int errors = 0, checks = 0;
  // packed expectation: {done, tag[1:0], valid, cp, rs, phi1, sh}
  localparam logic [7:0] IDLE_V = 8'b0000_0010;
  logic [7:0] q[$];
  logic [7:0] expv = IDLE_V;
  longint cyc = 0, last_acc = 0;
  bit armed = 0;
  bit run = 0;

  function automatic logic [7:0] mk(bit sh_b, bit p1, bit r, bit c, bit v, int tg, bit d);
    return {d, 2'(tg), v, c, r, p1, sh_b};
  endfunction

  task automatic build_line();
    int p, t, tg;
    bit r, c;
    for (int k = 0; k < cfg_lead; k++) q.push_back(mk(0, 1, 0, 0, 0, 0, 0));
    for (int k = 0; k < cfg_sh_width; k++) q.push_back(mk(1, 1, 0, 0, 0, 0, 0));
    for (int k = 0; k < cfg_hold; k++) q.push_back(mk(0, 1, 0, 0, 0, 0, 0));
    for (p = 0; p < 3822; p++) begin
      if (p < 8) tg = 0;
      else if (p < 56) tg = 1;
      else if (p < 64) tg = 0;
      else if (p < 3814) tg = 2;
      else tg = 3;
      for (t = 0; t < cfg_period; t++) begin
        r = (t < cfg_rs_width);
        c = (t >= cfg_rs_width) && (t < cfg_rs_width + cfg_cp_width) &&
            (!cfg_line_clamp || p == 0);
        q.push_back(mk(0, t < (cfg_period / 2), r, c, tg == 2, tg, 0));
      end
    end
    q.push_back(mk(0, 1, 0, 0, 0, 0, 1));
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (!rst_n) begin
      q.delete();
      expv = IDLE_V;
      armed = 0;
    end else begin
      bit acc;
      acc = start && (q.size() <= 1) && (!armed || (cyc - last_acc) >= longint'(cfg_integ));
      expv = (q.size() > 0) ? q.pop_front() : IDLE_V;
      if (acc) begin
        armed = 1;
        last_acc = cyc;
        build_line();
      end
    end
  end

  task automatic chk(string req, logic act, logic ex);
    checks++;
    if (act !== ex) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%b expected=%b", req, cyc, act, ex);
    end
  endtask

  task automatic chk2(string req, logic [1:0] act, logic [1:0] ex);
    checks++;
    if (act !== ex) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, ex);
    end
  endtask

  always @(negedge clk) begin
    if (run && rst_n) begin
      chk("R4 R8 R10 sh", sh, expv[0]);
      chk("R2 phi1a", phi1a, expv[1]);
      chk("R2 phi2a", phi2a, ~expv[1]);
      chk("R2 phi2b", phi2b, ~expv[1]);
      chk("R5 R6 rs", rs, expv[2]);
      chk(cfg_line_clamp ? "R5 R7 cp" : "R5 R6 cp", cp, expv[3]);
      chk("R3 pix_valid", pix_valid, expv[4]);
      chk2("R3 seg_tag", seg_tag, expv[6:5]);
      chk("R9 line_done", line_done, expv[7]);
    end
  end

  task automatic pulse(int n);
    @(negedge clk) start = 1'b1;
    repeat (n) @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset levels
    chk("R1 sh", sh, 1'b0);
    chk("R1 phi1a", phi1a, 1'b1);
    chk("R1 phi2a", phi2a, 1'b0);
    chk("R1 phi2b", phi2b, 1'b0);
    chk("R1 rs", rs, 1'b0);
    chk("R1 cp", cp, 1'b0);
    chk2("R1 seg_tag", seg_tag, 2'd0);
    chk("R1 line_done", line_done, 1'b0);
    rst_n = 1'b1;
    run = 1'b1;
    repeat (5) @(negedge clk);
    // line 1: bit clamp, even period; second start ignored (busy, R8)
    pulse(1);
    repeat (100) @(negedge clk);
    pulse(1);
    @(posedge line_done);
    repeat (2) @(negedge clk);
    // R8: integration interval not yet elapsed
    pulse(1);
    cfg_line_clamp = 1'b1;
    cfg_period = 16'd5;
    repeat (90) @(negedge clk);
    // line 2: line clamp (R7), odd period
    pulse(1);
    @(posedge line_done);
    repeat (3) @(negedge clk);
    cfg_line_clamp = 1'b0;
    cfg_period = 16'd4;
    cfg_rs_width = 16'd2;
    cfg_lead = 16'd2;
    cfg_sh_width = 16'd3;
    cfg_hold = 16'd5;
    cfg_integ = 32'd10;
    repeat (2) @(negedge clk);
    // line 3: start held two clocks launches one line (R10)
    pulse(2);
    @(posedge line_done);
    repeat (20) @(negedge clk);
    run = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule